// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit input vectors by a square matrix of signed 8-bit weights. The multiply uses an N x N grid of multiply-accumulate cells. Weights arrive one row per cycle on a load stream and shift down the grid columns into a second, hidden weight bank in each cell. A one-cycle bank swap makes the loaded set active. The active weights stay in place for a whole batch, so every weight is reused by every vector in that batch. A new set can be loaded while the current batch is computing.

Input vectors enter one per cycle. Each vector carries a target accumulator row address and a last-of-batch flag. Element k enters the grid k cycles late, and output column j is delayed so that all N sums of a vector leave the grid together. Each result row is then written into an internal accumulator memory. The write either replaces the addressed row or adds to it. The replace or add choice is taken from the first vector of each batch. Every accumulator write also appears on a registered write port, and a one-cycle done pulse marks the write of the last row of a batch. A separate read port returns any accumulator row one cycle after its address is presented.

Top module: `ws_matmul`

## Requirements
- R1: While reset is high, and in every cycle after reset until the first vector has passed through, `acc_we` and `batch_done` are 0.
- R2: For an input vector x, with element k in `vin_data[8k+7:8k]`, result lane j in bits `[32j+31:32j]` is the 32-bit two's-complement sum over k of x[k]*W[k][j]. All operands are signed 8-bit, and results are exact even where they exceed 16 bits.
- R3: A weight set is loaded in N beats of `wl_valid`. In each beat, `wl_row[8j+7:8j]` goes to column j. The row given at beat i (counting from 0) becomes weight row N-1-i. The set has no effect on results until a `bank_swap` pulse, and each pulse toggles which bank is active.
- R4: Loading a weight set into the hidden bank while a batch is streaming leaves that batch's results unchanged.
- R5: A vector sampled on clock edge P appears on the write port after edge P+2N+1. It appears with `acc_waddr` equal to its `vin_addr`.
- R6: B vectors presented on consecutive cycles produce B writes on consecutive cycles, in input order.
- R7: If `vin_ovw` is 1 on the first vector of a batch, every row of that batch replaces the addressed accumulator row. If it is 0, every row of the batch adds to the addressed row. The value of `vin_ovw` on later vectors of the batch is ignored. A batch starts at the first valid vector after reset or after a vector with `vin_last` set.
- R8: Consecutive add-mode writes to the same row all take effect; none is lost.
- R9: `batch_done` is high for exactly one cycle, the cycle in which the write port shows the row of the vector that carried `vin_last`. It is never high without `acc_we`.
- R10: `rd_data` equals the accumulator row at `rd_addr` one cycle after the address is presented. After a write, that row equals `acc_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_valid | input | 1 | Weight-row beat valid |
| wl_row | input | N*8 | Weight row, column j in byte j |
| bank_swap | input | 1 | Pulse: make the loaded weight bank active |
| vin_valid | input | 1 | Input vector valid |
| vin_last | input | 1 | Vector is the last of its batch |
| vin_addr | input | AB | Target accumulator row |
| vin_ovw | input | 1 | Batch mode on first vector: 1 replace, 0 add |
| vin_data | input | N*8 | Input vector, element k in byte k |
| acc_we | output | 1 | Accumulator write strobe |
| acc_waddr | output | AB | Row being written |
| acc_wdata | output | N*32 | New contents of the written row |
| batch_done | output | 1 | Last row of a batch was written |
| rd_addr | input | AB | Accumulator read address |
| rd_data | output | N*32 | Accumulator row, one cycle after address |

## Verification
The bench uses a non-symmetric weight matrix. A grid that placed load beats in the wrong rows, or that mixed up rows and columns, would therefore give visibly wrong sums. It sends add-mode vectors back to back to the same row; a read-modify-write without forwarding would drop all but one of them. It flips `vin_ovw` in the middle of a batch, which exposes a design that samples the mode on every vector. It streams a batch while the hidden bank is loading, and a leak between banks would corrupt that batch. Full-scale negative operands overflow 16 bits and catch a narrow or unsigned accumulator. Write timestamps catch any error in skew or de-skew depth and any lost pipeline slot.

// File: rtl/ws_matmul_pkg.sv
package ws_matmul_pkg;

  typedef enum logic {
    ACC_ADD       = 1'b0,
    ACC_OVERWRITE = 1'b1
  } acc_op_e;

  typedef struct packed {
    logic valid;
    logic last;
    logic ovw;
  } sa_tag_t;

endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (D == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] sr [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < D; i++) sr[i] <= '0;
        end else begin
          sr[0] <= din;
          for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
        end
      end
      assign dout = sr[D-1];
    end
  endgenerate

endmodule

// File: rtl/sa_cell.sv
module sa_cell #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic [AW-1:0] p_in,
  input  logic          wl_en,
  input  logic [DW-1:0] w_in,
  input  logic          bank_sel,
  output logic [DW-1:0] a_out,
  output logic [AW-1:0] p_out,
  output logic [DW-1:0] w_out
);

  localparam int PW = 2 * DW;

  logic [DW-1:0] w_bank0, w_bank1;
  logic [DW-1:0] w_act;
  logic signed [PW-1:0] prod;
  logic [AW-1:0] prod_ext;

  // bank_sel names the active bank; loads go to the other one
  assign w_act    = bank_sel ? w_bank1 : w_bank0;
  assign w_out    = bank_sel ? w_bank0 : w_bank1;
  assign prod     = $signed(a_in) * $signed(w_act);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_bank0 <= '0;
      w_bank1 <= '0;
    end else if (wl_en) begin
      if (bank_sel) w_bank0 <= w_in;
      else          w_bank1 <= w_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      p_out <= '0;
    end else begin
      a_out <= a_in;
      p_out <= p_in + prod_ext;
    end
  end

endmodule

// File: rtl/sa_grid.sv
module sa_grid #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N*DW-1:0] x_flat,
  input  logic            wl_en,
  input  logic [N*DW-1:0] wl_row,
  input  logic            bank_sel,
  output logic [N*AW-1:0] y_flat
);

  logic [DW-1:0] a_bus [N][N+1];
  logic [AW-1:0] p_bus [N+1][N];
  logic [DW-1:0] w_bus [N+1][N];

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_skew
      sa_delay #(.W(DW), .D(r)) u_skew (
        .clk (clk),
        .rst (rst),
        .din (x_flat[r*DW +: DW]),
        .dout(a_bus[r][0])
      );
    end

    for (c = 0; c < N; c++) begin : g_col
      assign p_bus[0][c] = '0;
      assign w_bus[0][c] = wl_row[c*DW +: DW];
      sa_delay #(.W(AW), .D(N-1-c)) u_deskew (
        .clk (clk),
        .rst (rst),
        .din (p_bus[N][c]),
        .dout(y_flat[c*AW +: AW])
      );
    end

    for (r = 0; r < N; r++) begin : g_row
      for (c = 0; c < N; c++) begin : g_cell
        sa_cell #(.DW(DW), .AW(AW)) u_cell (
          .clk     (clk),
          .rst     (rst),
          .a_in    (a_bus[r][c]),
          .p_in    (p_bus[r][c]),
          .wl_en   (wl_en),
          .w_in    (w_bus[r][c]),
          .bank_sel(bank_sel),
          .a_out   (a_bus[r][c+1]),
          .p_out   (p_bus[r+1][c]),
          .w_out   (w_bus[r+1][c])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/sa_accum.sv
module sa_accum
  import ws_matmul_pkg::*;
#(
  parameter int N    = 8,
  parameter int AW   = 32,
  parameter int ROWS = 16,
  parameter int AB   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic            in_ovw,
  input  logic [AB-1:0]   in_addr,
  input  logic [N*AW-1:0] in_row,
  input  logic [AB-1:0]   rd_addr,
  output logic            acc_we,
  output logic [AB-1:0]   acc_waddr,
  output logic [N*AW-1:0] acc_wdata,
  output logic            done,
  output logic [N*AW-1:0] rd_data
);

  localparam int RW = N * AW;

  logic [RW-1:0] mem [ROWS];

  // stage A: memory read of the target row
  logic          va_q, la_q, oa_q;
  logic [AB-1:0] aa_q;
  logic [RW-1:0] ra_q, acc_q;

  // write stage outputs
  logic          we_q, done_q;
  logic [AB-1:0] waddr_q;
  logic [RW-1:0] wdata_q, rd_q;

  logic [RW-1:0] base, sum;
  acc_op_e       op;

  assign op = acc_op_e'(oa_q);
  // the row written in the previous cycle is newer than what was read
  assign base = (we_q && waddr_q == aa_q) ? wdata_q : acc_q;

  genvar l;
  generate
    for (l = 0; l < N; l++) begin : g_lane
      assign sum[l*AW +: AW] = (op == ACC_OVERWRITE) ? ra_q[l*AW +: AW]
                                                      : base[l*AW +: AW] + ra_q[l*AW +: AW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (va_q) mem[aa_q] <= sum;
    acc_q <= mem[in_addr];
    rd_q  <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q    <= 1'b0;
      la_q    <= 1'b0;
      oa_q    <= 1'b0;
      aa_q    <= '0;
      ra_q    <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      va_q    <= in_valid;
      la_q    <= in_last;
      oa_q    <= in_ovw;
      aa_q    <= in_addr;
      ra_q    <= in_row;
      we_q    <= va_q;
      done_q  <= va_q && la_q;
      if (va_q) begin
        waddr_q <= aa_q;
        wdata_q <= sum;
      end
    end
  end

  assign acc_we    = we_q;
  assign acc_waddr = waddr_q;
  assign acc_wdata = wdata_q;
  assign done      = done_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/ws_matmul.sv
module ws_matmul
  import ws_matmul_pkg::*;
#(
  parameter int N    = 8,
  parameter int DW   = 8,
  parameter int AW   = 32,
  parameter int ROWS = 16,
  localparam int AB  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wl_valid,
  input  logic [N*DW-1:0] wl_row,
  input  logic            bank_swap,
  input  logic            vin_valid,
  input  logic            vin_last,
  input  logic [AB-1:0]   vin_addr,
  input  logic            vin_ovw,
  input  logic [N*DW-1:0] vin_data,
  output logic            acc_we,
  output logic [AB-1:0]   acc_waddr,
  output logic [N*AW-1:0] acc_wdata,
  output logic            batch_done,
  input  logic [AB-1:0]   rd_addr,
  output logic [N*AW-1:0] rd_data
);

  localparam int TAGW = $bits(sa_tag_t) + AB;
  localparam int LAT  = 2 * N;

  logic            bank_q;
  logic [N*DW-1:0] x_q;
  logic            open_q, mode_q, ovw_eff;
  sa_tag_t         tag_in, tag_out;
  logic [AB-1:0]   addr_out;
  logic [N*AW-1:0] y_res;

  always_ff @(posedge clk) begin
    if (rst)            bank_q <= 1'b0;
    else if (bank_swap) bank_q <= ~bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) x_q <= '0;
    else     x_q <= vin_valid ? vin_data : '0;
  end

  // batch mode is taken from the first vector and held to the last
  assign ovw_eff = open_q ? mode_q : vin_ovw;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (vin_valid) begin
      open_q <= ~vin_last;
      mode_q <= ovw_eff;
    end
  end

  assign tag_in = '{valid: vin_valid, last: vin_valid & vin_last, ovw: ovw_eff};

  sa_delay #(.W(TAGW), .D(LAT)) u_tag_dly (
    .clk (clk),
    .rst (rst),
    .din ({tag_in, vin_addr}),
    .dout({tag_out, addr_out})
  );

  sa_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk     (clk),
    .rst     (rst),
    .x_flat  (x_q),
    .wl_en   (wl_valid),
    .wl_row  (wl_row),
    .bank_sel(bank_q),
    .y_flat  (y_res)
  );

  sa_accum #(.N(N), .AW(AW), .ROWS(ROWS), .AB(AB)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .in_valid (tag_out.valid),
    .in_last  (tag_out.last),
    .in_ovw   (tag_out.ovw),
    .in_addr  (addr_out),
    .in_row   (y_res),
    .rd_addr  (rd_addr),
    .acc_we   (acc_we),
    .acc_waddr(acc_waddr),
    .acc_wdata(acc_wdata),
    .done     (batch_done),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/ws_matmul_chk.sv
module ws_matmul_chk #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int AB = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            vin_valid,
  input logic            vin_last,
  input logic            acc_we,
  input logic [AB-1:0]   acc_waddr,
  input logic [N*AW-1:0] acc_wdata,
  input logic            batch_done,
  input logic [AB-1:0]   rd_addr,
  input logic [N*AW-1:0] rd_data
);

  localparam int LAT = 2 * N + 1;

  logic [LAT:0] vh, lh;

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0;
      lh <= '0;
    end else begin
      vh <= {vh[LAT-1:0], vin_valid};
      lh <= {lh[LAT-1:0], vin_valid & vin_last};
    end
  end

  assert_write_timing_R5: assert property (@(posedge clk) disable iff (rst)
    acc_we == vh[LAT]);

  assert_done_timing_R9: assert property (@(posedge clk) disable iff (rst)
    batch_done == lh[LAT]);

  assert_done_with_write_R9: assert property (@(posedge clk) disable iff (rst)
    batch_done |-> acc_we);

  assert_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_we && rd_addr == acc_waddr) |=> rd_data == $past(acc_wdata));

endmodule

bind ws_matmul ws_matmul_chk #(.N(N), .AW(AW), .AB(AB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vin_valid (vin_valid),
  .vin_last  (vin_last),
  .acc_we    (acc_we),
  .acc_waddr (acc_waddr),
  .acc_wdata (acc_wdata),
  .batch_done(batch_done),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/ws_matmul_bench.sv
module ws_matmul_bench;

  localparam int N    = 8;
  localparam int DW   = 8;
  localparam int AW   = 32;
  localparam int ROWS = 16;
  localparam int AB   = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic            wl_valid, bank_swap, vin_valid, vin_last, vin_ovw;
  logic [N*DW-1:0] wl_row, vin_data;
  logic [AB-1:0]   vin_addr, rd_addr, acc_waddr;
  logic            acc_we, batch_done;
  logic [N*AW-1:0] acc_wdata, rd_data;

  ws_matmul #(.N(N), .DW(DW), .AW(AW), .ROWS(ROWS)) u_ws_matmul (
    .clk(clk), .rst(rst), .wl_valid(wl_valid), .wl_row(wl_row),
    .bank_swap(bank_swap), .vin_valid(vin_valid), .vin_last(vin_last),
    .vin_addr(vin_addr), .vin_ovw(vin_ovw), .vin_data(vin_data),
    .acc_we(acc_we), .acc_waddr(acc_waddr), .acc_wdata(acc_wdata),
    .batch_done(batch_done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int wm [3][N][N];
  int xv [8][N];
  int mdl [ROWS][N];

  logic [N*AW-1:0] log_data [256];
  int  log_addr [256];
  int  log_cyc  [256];
  bit  log_done [256];
  int  nlog = 0;
  int  stray_done = 0;

  always @(negedge clk) begin
    if (!rst && acc_we && nlog < 256) begin
      log_data[nlog] = acc_wdata;
      log_addr[nlog] = int'(acc_waddr);
      log_cyc[nlog]  = cyc;
      log_done[nlog] = batch_done;
      nlog = nlog + 1;
    end
    if (!rst && batch_done && !acc_we) stray_done = stray_done + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int yexp(input int set, input int v, input int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += xv[v][k] * wm[set][k][j];
    return s;
  endfunction

  task automatic load_weights(input int set);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wl_valid = 1'b1;
      for (int j = 0; j < N; j++) wl_row[j*DW +: DW] = 8'(wm[set][N-1-i][j]);
    end
    @(negedge clk);
    wl_valid = 1'b0;
  endtask

  task automatic swap_bank();
    @(negedge clk); bank_swap = 1'b1;
    @(negedge clk); bank_swap = 1'b0;
  endtask

  // streams b vectors back to back, waits for drain, checks every write
  task automatic run_batch(input int set, input int b, input int addr0, input int step,
                           input bit ovw_first, input bit ovw_rest, input string req);
    int c0, base, a, e;
    bit ok, ovw_mode;
    base = nlog;
    ovw_mode = ovw_first;
    for (int v = 0; v < b; v++) begin
      @(negedge clk);
      if (v == 0) c0 = cyc;
      vin_valid = 1'b1;
      vin_last  = (v == b - 1);
      vin_addr  = AB'(addr0 + v * step);
      vin_ovw   = (v == 0) ? ovw_first : ovw_rest;
      for (int k = 0; k < N; k++) vin_data[k*DW +: DW] = 8'(xv[v][k]);
    end
    @(negedge clk);
    vin_valid = 1'b0; vin_last = 1'b0;
    repeat (2 * N + 4) @(negedge clk);
    chk(nlog == base + b, "R6", "write count", nlog - base, b);
    for (int v = 0; v < b && base + v < nlog; v++) begin
      a = addr0 + v * step;
      chk(log_cyc[base+v] == c0 + 2*N + 2 + v, "R5/R6", "write cycle",
          log_cyc[base+v], c0 + 2*N + 2 + v);
      chk(log_addr[base+v] == a, "R5", "write address", log_addr[base+v], a);
      chk(log_done[base+v] == (v == b - 1), "R9", "done flag",
          log_done[base+v], (v == b - 1));
      ok = 1;
      for (int j = 0; j < N; j++) begin
        e = yexp(set, v, j);
        mdl[a][j] = ovw_mode ? e : mdl[a][j] + e;
        if (int'($signed(log_data[base+v][j*AW +: AW])) != mdl[a][j] && ok) begin
          ok = 0;
          chk(0, req, $sformatf("row data lane %0d", j),
              int'($signed(log_data[base+v][j*AW +: AW])), mdl[a][j]);
        end
      end
      if (ok) chk(1, req, "row data", 0, 0);
    end
  endtask

  task automatic read_row(input int a, input string req);
    bit ok = 1;
    @(negedge clk); rd_addr = AB'(a);
    @(negedge clk);
    for (int j = 0; j < N; j++)
      if (int'($signed(rd_data[j*AW +: AW])) != mdl[a][j] && ok) begin
        ok = 0;
        chk(0, req, $sformatf("readback row %0d lane %0d", a, j),
            int'($signed(rd_data[j*AW +: AW])), mdl[a][j]);
      end
    if (ok) chk(1, req, "readback", 0, 0);
  endtask

  task automatic set_vecs(input int seed);
    for (int v = 0; v < 8; v++)
      for (int k = 0; k < N; k++) xv[v][k] = ((v * 37 + k * 11 + seed) % 256) - 128;
  endtask

  task automatic t_reset();
    bit quiet = 1;
    repeat (6) begin
      @(negedge clk);
      if (acc_we || batch_done) quiet = 0;
    end
    chk(quiet, "R1", "outputs idle after reset", acc_we, 0);
  endtask

  task automatic t_single();
    load_weights(0);
    swap_bank();
    set_vecs(5);
    run_batch(0, 1, 3, 0, 1'b1, 1'b1, "R2/R3");
  endtask

  task automatic t_stream();
    set_vecs(91);
    run_batch(0, 5, 0, 1, 1'b1, 1'b1, "R2/R6");
    read_row(4, "R10");
  endtask

  task automatic t_add_same_row();
    set_vecs(17);
    run_batch(0, 3, 2, 0, 1'b0, 1'b1, "R7/R8");
    read_row(2, "R8");
  endtask

  task automatic t_overwrite_latched();
    set_vecs(200);
    run_batch(0, 2, 5, 0, 1'b1, 1'b0, "R7");
    read_row(5, "R7");
  endtask

  task automatic t_double_buffer();
    set_vecs(63);
    fork
      load_weights(1);
      run_batch(0, 4, 8, 1, 1'b1, 1'b1, "R4");
    join
    swap_bank();
    set_vecs(140);
    run_batch(1, 2, 12, 1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_extremes();
    load_weights(2);
    swap_bank();
    for (int k = 0; k < N; k++) begin
      xv[0][k] = -128;
      xv[1][k] = 127;
      xv[2][k] = (k % 2) ? -128 : 127;
    end
    run_batch(2, 3, 9, 1, 1'b1, 1'b1, "R2");
    read_row(9, "R10");
  endtask

  initial begin
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) begin
        wm[0][k][j] = ((k * 13 + j * 7 + 3) % 255) - 127;
        wm[1][k][j] = ((k * 5 + j * 29 + 11) % 200) - 100;
        wm[2][k][j] = (k == 0 || ((k + j) % 2 == 0)) ? -128 : 127;
      end
    for (int a = 0; a < ROWS; a++)
      for (int j = 0; j < N; j++) mdl[a][j] = 0;
    rst = 1'b1;
    wl_valid = 0; wl_row = '0; bank_swap = 0;
    vin_valid = 0; vin_last = 0; vin_addr = '0; vin_ovw = 0; vin_data = '0;
    rd_addr = '0;
    repeat (4) @(negedge clk);
    chk(!acc_we && !batch_done, "R1", "outputs in reset", acc_we, 0);
    rst = 1'b0;
    t_reset();
    t_single();
    t_stream();
    t_add_same_row();
    t_overwrite_latched();
    t_double_buffer();
    t_extremes();
    chk(stray_done == 0, "R9", "done without write", stray_done, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

endmodule